// File: doc/BRIEF.md
# DMA Channel Trigger and Transfer-Mode Controller

This block is the per-channel control logic of a multi-channel DMA engine. It decides when the channel asks the arbiter for a word transfer. A 5-bit source code picks one request line out of several groups: external pins, the block-done pulses of the sibling channels, and peripheral request lines. The chosen line is sampled as a synchronous input and only its rising edge counts. A captured edge becomes a single pending flag. The flag is raised toward the arbiter and cleared when the arbiter grants the unit of work.

A 3-bit transfer mode sets three things: how much data one trigger moves (one word, one line or a whole block), whether a hardware edge or the software enable starts the work, and whether the enable bit clears itself at the end of the block. The block also holds the enable bit, a done status bit and a sticky interrupt request. For peripherals that can request at the full transfer rate, it runs a handshake. It drives an enable line to the peripheral, drops it on each trigger pulse, and raises it again once the arbiter has scheduled that trigger. The address generator reports word completion together with end-of-line and end-of-block flags. Bus access and address generation are handled elsewhere.

Top module: `xch_trig_ctrl`

## Requirements
- R1: Source code decoding: codes 0 to 3 select `ext_pin_i[code]`, codes 4 to 9 select `ch_done_i[code-4]`, and codes 10 to 31 select `periph_req_i[code-10]`. Edges on lines that are not selected have no effect on `req_o`.
- R2: Only a rising edge of the selected line is a trigger. A line held high for many cycles yields one trigger.
- R3: While enabled, a trigger edge sampled at clock edge N raises `req_o` after edge N. The trigger is held as one pending flag, and `grant_i` clears it. `req_o` is low in the cycle after any grant and stays low while that word is in flight, until `word_done_i`.
- R4: Unit per trigger. In word modes (001, 101) each trigger yields exactly one request. In line mode (010) `req_o` stays asserted between words until a `word_done_i` with `eol_i`. In block modes it stays asserted until a `word_done_i` with `eob_i`.
- R5: Mode 011 ignores hardware edges. A pulse on `en_set_i` while disabled starts a block, and `req_o` is high after that edge.
- R6: Modes 000, 001, 010 and 011 clear `en_o` at end of block. Modes 100 and 101 keep `en_o` high at end of block and accept later triggers.
- R7: Reserved modes 110 and 111 capture no trigger, so `req_o` stays low.
- R8: A pulse on `en_clr_i` while enabled drops `en_o` after that edge. In line and block modes it also withdraws any further request. `done_o` rises one cycle after the cycle in which the word in flight completes, or one cycle after the clear if no word is in flight.
- R9: In word modes, a trigger captured before a software clear is still requested and served. `done_o` rises only one cycle after that word completes.
- R10: `done_o` rises after the edge that samples `word_done_i` with `eob_i`. It falls after an edge that samples `en_set_i`.
- R11: When `irq_en_i` is high, `irq_o` rises together with `done_o` and stays high until `irq_ack_i` is sampled. When `irq_en_i` is low, `irq_o` stays low.
- R12: With source codes 28 to 31 in a word mode, `fast_en_o` rises two cycles after enable. It falls after the edge that samples a trigger pulse and rises again after the edge that samples `grant_i`. In any other mode `fast_en_o` stays low.
- R13: After synchronous reset, `req_o`, `en_o`, `done_o`, `irq_o` and `fast_en_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel_i | input | SEL_W (5) | Trigger source code |
| xfer_mode_i | input | 3 | Transfer mode code |
| irq_en_i | input | 1 | Interrupt enable |
| en_set_i | input | 1 | Software writes enable = 1 (pulse) |
| en_clr_i | input | 1 | Software writes enable = 0 (pulse) |
| ext_pin_i | input | NUM_EXT (4) | External request pins |
| ch_done_i | input | NUM_CH (6) | Block-done pulses from all channels |
| periph_req_i | input | NUM_PERIPH (22) | Peripheral request lines |
| grant_i | input | 1 | Arbiter grants one word to this channel |
| word_done_i | input | 1 | Current word has been written to its destination |
| eol_i | input | 1 | Completed word was the last of a line |
| eob_i | input | 1 | Completed word was the last of the block |
| irq_ack_i | input | 1 | Interrupt serviced |
| req_o | output | 1 | Pending request to the arbiter |
| en_o | output | 1 | Channel enable state |
| done_o | output | 1 | Transfer-done status |
| irq_o | output | 1 | End-of-block interrupt request |
| fast_en_o | output | 1 | Re-arm line to a fast request source |

## Verification
Every output is a flop. So `req_o`, `en_o`, `done_o` and `irq_o` respond one cycle after the edge that samples their cause. The exception is the done that follows a software clear: it waits one more cycle after the word in flight finishes. `fast_en_o` appears two cycles after enable, because the enable must first land in its register. The bench drives inputs just after a rising edge and samples outputs 2 ns after the following edge, so each check reads the cycle in which the result is due. The random phases keep the source code fixed and carry their own edge and pending model. They compare `req_o` every cycle while grants and completions arrive at random times.

// File: rtl/xch_pkg.sv
package xch_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    UNIT_WORD  = 2'd0,
    UNIT_LINE  = 2'd1,
    UNIT_BLOCK = 2'd2
  } unit_e;

  typedef struct packed {
    logic  valid;     // mode code is not reserved
    logic  hw_trig;   // started by a request edge (else by enable)
    logic  auto_clr;  // enable drops at end of block
    unit_e unit;      // amount of work per trigger
  } mode_t;
endpackage

// File: rtl/xch_mode_dec.sv
module xch_mode_dec
  import xch_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output mode_t             dec_o
);
  always_comb begin
    dec_o = '{valid: 1'b0, hw_trig: 1'b1, auto_clr: 1'b1, unit: UNIT_BLOCK};
    unique case (mode_i)
      3'b000: dec_o = '{valid: 1'b1, hw_trig: 1'b1, auto_clr: 1'b1, unit: UNIT_BLOCK};
      3'b001: dec_o = '{valid: 1'b1, hw_trig: 1'b1, auto_clr: 1'b1, unit: UNIT_WORD};
      3'b010: dec_o = '{valid: 1'b1, hw_trig: 1'b1, auto_clr: 1'b1, unit: UNIT_LINE};
      3'b011: dec_o = '{valid: 1'b1, hw_trig: 1'b0, auto_clr: 1'b1, unit: UNIT_BLOCK};
      3'b100: dec_o = '{valid: 1'b1, hw_trig: 1'b1, auto_clr: 1'b0, unit: UNIT_BLOCK};
      3'b101: dec_o = '{valid: 1'b1, hw_trig: 1'b1, auto_clr: 1'b0, unit: UNIT_WORD};
      default: dec_o = '{valid: 1'b0, hw_trig: 1'b1, auto_clr: 1'b1, unit: UNIT_BLOCK};
    endcase
  end
endmodule

// File: rtl/xch_src_edge.sv
module xch_src_edge #(
  parameter int SEL_W      = 5,
  parameter int NUM_EXT    = 4,
  parameter int NUM_CH     = 6,
  parameter int NUM_PERIPH = 22
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SEL_W-1:0]      code_i,
  input  logic [NUM_EXT-1:0]    ext_i,
  input  logic [NUM_CH-1:0]     chd_i,
  input  logic [NUM_PERIPH-1:0] per_i,
  output logic                  edge_o
);
  localparam int TOTAL = NUM_EXT + NUM_CH + NUM_PERIPH;
  localparam int SPAN  = 1 << SEL_W;

  logic [SPAN-1:0] lines;
  logic            sel;
  logic            sel_q;

  generate
    if (TOTAL >= SPAN) begin : g_trim
      logic [TOTAL-1:0] all_src;
      assign all_src = {per_i, chd_i, ext_i};
      assign lines   = all_src[SPAN-1:0];
    end else begin : g_pad
      assign lines = {{(SPAN-TOTAL){1'b0}}, per_i, chd_i, ext_i};
    end
  endgenerate

  assign sel = lines[code_i];

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else     sel_q <= sel;
  end

  assign edge_o = sel & ~sel_q;
endmodule

// File: rtl/xch_fast_line.sv
module xch_fast_line (
  input  logic clk,
  input  logic rst,
  input  logic fast_ok_i,
  input  logic trig_i,
  input  logic grant_i,
  input  logic pend_i,
  output logic fast_en_o
);
  always_ff @(posedge clk) begin
    if (rst) fast_en_o <= 1'b0;
    else     fast_en_o <= fast_ok_i & ~trig_i & (grant_i | ~pend_i);
  end
endmodule

// File: rtl/xch_trig_ctrl.sv
module xch_trig_ctrl
  import xch_pkg::*;
#(
  parameter int SEL_W      = 5,
  parameter int NUM_EXT    = 4,
  parameter int NUM_CH     = 6,
  parameter int NUM_PERIPH = 22
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SEL_W-1:0]      src_sel_i,
  input  logic [MODE_W-1:0]     xfer_mode_i,
  input  logic                  irq_en_i,
  input  logic                  en_set_i,
  input  logic                  en_clr_i,
  input  logic [NUM_EXT-1:0]    ext_pin_i,
  input  logic [NUM_CH-1:0]     ch_done_i,
  input  logic [NUM_PERIPH-1:0] periph_req_i,
  input  logic                  grant_i,
  input  logic                  word_done_i,
  input  logic                  eol_i,
  input  logic                  eob_i,
  input  logic                  irq_ack_i,
  output logic                  req_o,
  output logic                  en_o,
  output logic                  done_o,
  output logic                  irq_o,
  output logic                  fast_en_o
);
  localparam int FAST_W = 3;

  mode_t md;
  logic  src_edge;
  logic  en_q, drain_q, pend_q, busy_q, inflight_q, done_q, irq_q, req_q;
  logic  en_n, drain_n, pend_n, busy_n, inflight_n, done_n, irq_n, req_n;
  logic  sw_trig, hw_trig, is_word, end_word, blk_end, unit_end;
  logic  sw_stop, auto_stop, drain_done, set_ev, fast_ok;

  xch_mode_dec u_dec (.mode_i(xfer_mode_i), .dec_o(md));

  xch_src_edge #(
    .SEL_W(SEL_W), .NUM_EXT(NUM_EXT), .NUM_CH(NUM_CH), .NUM_PERIPH(NUM_PERIPH)
  ) u_src (
    .clk(clk), .rst(rst), .code_i(src_sel_i), .ext_i(ext_pin_i),
    .chd_i(ch_done_i), .per_i(periph_req_i), .edge_o(src_edge)
  );

  always_comb begin
    is_word    = (md.unit == UNIT_WORD);
    sw_trig    = md.valid & ~md.hw_trig & en_set_i & ~en_q;
    hw_trig    = md.valid & md.hw_trig & en_q & src_edge;
    end_word   = word_done_i & inflight_q;
    blk_end    = end_word & eob_i;
    unit_end   = end_word & (is_word | eob_i | ((md.unit == UNIT_LINE) & eol_i));
    sw_stop    = en_clr_i & en_q & ~en_set_i;
    auto_stop  = blk_end & md.auto_clr;
    drain_done = drain_q & ~inflight_q & (~pend_q | ~is_word);
    set_ev     = blk_end | drain_done;

    if (en_set_i)                 en_n = 1'b1;
    else if (sw_stop | auto_stop) en_n = 1'b0;
    else                          en_n = en_q;

    if (en_set_i)        drain_n = 1'b0;
    else if (sw_stop)    drain_n = 1'b1;
    else if (drain_done) drain_n = 1'b0;
    else                 drain_n = drain_q;

    if ((sw_stop & ~is_word) | auto_stop) pend_n = 1'b0;
    else if (sw_trig | hw_trig)           pend_n = 1'b1;
    else if (grant_i & ~busy_q)           pend_n = 1'b0;
    else                                  pend_n = pend_q;

    if (sw_stop | auto_stop)                          busy_n = 1'b0;
    else if (grant_i & pend_q & ~busy_q & ~is_word)   busy_n = 1'b1;
    else if (unit_end)                                busy_n = 1'b0;
    else                                              busy_n = busy_q;

    if (grant_i)       inflight_n = 1'b1;
    else if (end_word) inflight_n = 1'b0;
    else               inflight_n = inflight_q;

    if (set_ev)        done_n = 1'b1;
    else if (en_set_i) done_n = 1'b0;
    else               done_n = done_q;

    if (set_ev & irq_en_i) irq_n = 1'b1;
    else if (irq_ack_i)    irq_n = 1'b0;
    else                   irq_n = irq_q;

    req_n = ~inflight_n & ((pend_n & (en_n | drain_n)) | (busy_n & en_n));

    fast_ok = en_q & md.valid & is_word & (&src_sel_i[SEL_W-1:SEL_W-FAST_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; drain_q <= 1'b0; pend_q <= 1'b0; busy_q <= 1'b0;
      inflight_q <= 1'b0; done_q <= 1'b0; irq_q <= 1'b0; req_q <= 1'b0;
    end else begin
      en_q <= en_n; drain_q <= drain_n; pend_q <= pend_n; busy_q <= busy_n;
      inflight_q <= inflight_n; done_q <= done_n; irq_q <= irq_n; req_q <= req_n;
    end
  end

  xch_fast_line u_fast (
    .clk(clk), .rst(rst), .fast_ok_i(fast_ok), .trig_i(src_edge),
    .grant_i(grant_i), .pend_i(pend_q), .fast_en_o(fast_en_o)
  );

  assign req_o  = req_q;
  assign en_o   = en_q;
  assign done_o = done_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/xch_trig_ctrl_chk.sv
module xch_trig_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic grant_i,
  input logic word_done_i,
  input logic eob_i,
  input logic en_set_i,
  input logic irq_ack_i,
  input logic req_o,
  input logic en_o,
  input logic done_o,
  input logic irq_o,
  input logic fast_en_o
);
  // R3: no request while a granted word is in flight
  a_r3_quiet_after_grant: assert property (@(posedge clk) disable iff (rst)
    grant_i |=> !req_o);

  // R11: interrupt request is sticky until acknowledged
  a_r11_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !irq_ack_i) |=> irq_o);

  // R12: the re-arm line only follows an enabled channel
  a_r12_fast_needs_en: assert property (@(posedge clk) disable iff (rst)
    fast_en_o |-> $past(en_o));

  // R5: the enable bit only rises through a software write
  a_r5_en_by_write: assert property (@(posedge clk) disable iff (rst)
    $rose(en_o) |-> $past(en_set_i));

  // R10: done rises at end of block or after the enable has been cleared
  a_r10_done_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> (!en_o || $past(word_done_i && eob_i)));
endmodule

bind xch_trig_ctrl xch_trig_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .grant_i(grant_i), .word_done_i(word_done_i),
  .eob_i(eob_i), .en_set_i(en_set_i), .irq_ack_i(irq_ack_i),
  .req_o(req_o), .en_o(en_o), .done_o(done_o), .irq_o(irq_o),
  .fast_en_o(fast_en_o)
);

// File: tb/xch_trig_ctrl_tb_top.sv
`timescale 1ns/1ps
module xch_trig_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  src_sel;
  logic [2:0]  mode;
  logic        irq_en, en_set, en_clr, grant, wdone, eol, eob, irq_ack;
  logic [3:0]  pins;
  logic [5:0]  chd;
  logic [21:0] per;
  logic        req, en, done, irq, fast_en;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xch_trig_ctrl dut_i (
    .clk(clk), .rst(rst), .src_sel_i(src_sel), .xfer_mode_i(mode),
    .irq_en_i(irq_en), .en_set_i(en_set), .en_clr_i(en_clr),
    .ext_pin_i(pins), .ch_done_i(chd), .periph_req_i(per),
    .grant_i(grant), .word_done_i(wdone), .eol_i(eol), .eob_i(eob),
    .irq_ack_i(irq_ack), .req_o(req), .en_o(en), .done_o(done),
    .irq_o(irq), .fast_en_o(fast_en)
  );

  function automatic logic src_bit(input int code, input logic [3:0] p,
                                   input logic [5:0] d, input logic [21:0] q);
    if (code < 4)  return p[code];
    if (code < 10) return d[code-4];
    if (code < 32) return q[code-10];
    return 1'b0;
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
    en_set = 0; en_clr = 0; grant = 0; wdone = 0; eol = 0; eob = 0; irq_ack = 0;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [2:0] m, input logic [4:0] code);
    rst = 1; mode = m; src_sel = code; irq_en = 0;
    pins = 0; chd = 0; per = 0;
    en_set = 0; en_clr = 0; grant = 0; wdone = 0; eol = 0; eob = 0; irq_ack = 0;
    tick(); tick();
    rst = 0;
  endtask

  task automatic rand_run(input logic [4:0] code, input int n);
    logic prev = 0;
    logic pend_m = 0;
    logic infl_m = 0;
    logic sel, edg;
    do_reset(3'b001, code);
    en_set = 1; tick();
    for (int i = 0; i < n; i++) begin
      if (($urandom % 3) == 0) pins = pins ^ 4'($urandom);
      if (($urandom % 3) == 0) chd  = chd  ^ 6'($urandom);
      if (($urandom % 3) == 0) per  = per  ^ 22'($urandom);
      grant = pend_m & ~infl_m & (($urandom % 2) == 0);
      wdone = infl_m;
      sel = src_bit(int'(code), pins, chd, per);
      edg = sel & ~prev;
      prev = sel;
      if (edg) pend_m = 1'b1; else if (grant) pend_m = 1'b0;
      if (grant) infl_m = 1'b1; else if (wdone) infl_m = 1'b0;
      tick();
      chk("R1/R2/R3 random req", req, pend_m & ~infl_m);
    end
    chk("R10 random no done", done, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd4242));

    // R13 reset state
    do_reset(3'b000, 5'd0);
    chk("R13 req", req, 0); chk("R13 en", en, 0); chk("R13 done", done, 0);
    chk("R13 irq", irq, 0); chk("R13 fast", fast_en, 0);

    // R5 software start, R4 block unit, R6 auto clear, R10/R11 done and irq
    do_reset(3'b011, 5'd0); irq_en = 1;
    pins = 4'hF; tick(); pins = 0; tick();
    chk("R5 hw edge ignored", req, 0);
    en_set = 1; tick();
    chk("R5 en", en, 1); chk("R5 req after enable", req, 1);
    grant = 1; tick(); chk("R3 quiet in flight", req, 0);
    wdone = 1; tick(); chk("R4 block keeps req", req, 1);
    grant = 1; tick();
    wdone = 1; eob = 1; tick();
    chk("R6 auto clear", en, 0); chk("R10 done at eob", done, 1);
    chk("R11 irq", irq, 1); chk("R4 block end req", req, 0);
    tick(); chk("R11 irq held", irq, 1);
    irq_ack = 1; tick(); chk("R11 irq ack", irq, 0); chk("R10 done held", done, 1);

    // R4 line unit, R1 unselected pin ignored
    do_reset(3'b010, 5'd2);
    en_set = 1; tick();
    pins = 4'b0010; tick(); pins = 0; tick();
    chk("R1 unselected pin", req, 0);
    pins = 4'b0100; tick(); pins = 0;
    chk("R1 selected pin", req, 1);
    grant = 1; tick();
    wdone = 1; tick(); chk("R4 line continues", req, 1);
    grant = 1; tick();
    wdone = 1; eol = 1; tick(); chk("R4 line end", req, 0);
    chk("R6 line keeps en mid block", en, 1);

    // R6 keep-enable word mode, channel-done source, R10 done clear
    do_reset(3'b101, 5'd7); irq_en = 0;
    en_set = 1; tick();
    chd = 6'b001000; tick(); chd = 0;
    chk("R1 channel done source", req, 1);
    grant = 1; tick();
    wdone = 1; eob = 1; tick();
    chk("R6 en kept", en, 1); chk("R10 done", done, 1); chk("R11 no irq", irq, 0);
    chk("R4 word one req", req, 0);
    chd = 6'b001000; tick(); chd = 0;
    chk("R6 retrigger", req, 1);
    en_set = 1; tick(); chk("R10 done cleared", done, 0);

    // R2 held level gives one trigger
    do_reset(3'b100, 5'd1);
    en_set = 1; tick();
    pins = 4'b0010; tick(); chk("R2 first edge", req, 1);
    grant = 1; tick();
    wdone = 1; eob = 1; tick();
    tick(); tick(); chk("R2 held level", req, 0);

    // R8 software clear mid block
    do_reset(3'b000, 5'd0); irq_en = 1;
    en_set = 1; tick();
    pins = 4'b0001; tick(); pins = 0;
    grant = 1; tick();
    en_clr = 1; tick();
    chk("R8 en low", en, 0); chk("R8 done wait", done, 0);
    wdone = 1; tick(); chk("R8 done not yet", done, 0); chk("R8 no req", req, 0);
    tick(); chk("R8 done", done, 1); chk("R8 irq", irq, 1);

    // R9 word mode clear serves captured trigger
    do_reset(3'b001, 5'd3);
    en_set = 1; tick();
    pins = 4'b1000; tick(); pins = 0;
    en_clr = 1; tick();
    chk("R9 en low", en, 0); chk("R9 req kept", req, 1);
    tick(); chk("R9 done waits", done, 0);
    grant = 1; tick();
    wdone = 1; tick(); chk("R9 done not yet", done, 0);
    tick(); chk("R9 done", done, 1);

    // R7 reserved mode
    do_reset(3'b110, 5'd0);
    en_set = 1; tick();
    pins = 4'b0001; tick(); pins = 0; tick();
    chk("R7 reserved 110", req, 0);
    do_reset(3'b111, 5'd0);
    en_set = 1; tick();
    pins = 4'b0001; tick(); pins = 0; tick();
    chk("R7 reserved 111", req, 0);

    // R12 fast handshake
    do_reset(3'b001, 5'd28);
    en_set = 1; tick(); chk("R12 fast not yet", fast_en, 0);
    tick(); chk("R12 fast up", fast_en, 1);
    per[18] = 1; tick(); per[18] = 0;
    chk("R12 fast drop", fast_en, 0); chk("R12 req", req, 1);
    grant = 1; tick(); chk("R12 fast rearm", fast_en, 1);
    do_reset(3'b000, 5'd28);
    en_set = 1; tick(); tick(); tick();
    chk("R12 block mode no fast", fast_en, 0);

    // random phases, word mode
    rand_run(5'd2, 150);
    rand_run(5'd6, 150);
    rand_run(5'd15, 150);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule